// File: doc/BRIEF.md
# Flash Instruction Admission Gate

This block sits between the instruction decoder of a serial NOR flash and the engines that act on instructions. For every decoded opcode it gives a verdict: admit or refuse. It does this by tracking four things: a write-enable latch, a timed inhibit window after the supply comes up, the supply-good level itself, and a deep power-down state. Only the class of an opcode matters to the gate. Addresses, data and the status-register protect bits are handled elsewhere.

Instructions arrive as a one-cycle `cmd_valid` strobe with `cmd_code`. The path has no `ready`, because the gate never applies back-pressure: it takes an instruction on every cycle that `cmd_valid` is high. One cycle later it pulses exactly one of `cmd_accept` or `cmd_reject`. The program/erase engine reports completion with `op_done`. The latch value `wel` feeds the status register. `inhibit` tells the rest of the chip that modifying work is locked out because the supply is low or the power-up window is still open.

Top module: `flash_cmd_gate`

## Requirements
- R1: While `supply_ok` is low, the gate holds its reset state. `wel` is 0, power-down is cleared and the window counter restarts. Every valid instruction is answered with `cmd_reject`.
- R2: `inhibit` is high while `supply_ok` is low. After the first clock edge at which `supply_ok` is sampled high, it stays high for exactly `PUW_CYCLES` edges. While it is high, write enable (06h) and all modifying opcodes are rejected.
- R3: After reset or a supply drop, `wel` reads 0.
- R4: Write enable (06h) outside the window and outside power-down is accepted, and it sets `wel` to 1.
- R5: The modifying opcodes are 02h, 20h, 52h, D8h, C7h, 60h and 01h. They are accepted only when `wel` is 1 and `inhibit` is 0. A rejected one leaves `wel` unchanged.
- R6: An `op_done` pulse clears `wel` on the next cycle. If a command arrives in the same cycle, its effect on the latch takes priority.
- R7: Write disable (04h) is accepted outside power-down, even inside the window, and it clears `wel` at once.
- R8: Power-down (B9h) is accepted and enters power-down. While powered down, every opcode except release (ABh) is rejected and changes nothing. ABh is accepted and leaves power-down, and `wel` keeps its value.
- R9: Any other opcode, including ABh outside power-down, is accepted whenever the supply is good and the gate is not powered down, whatever the state of `wel` or the window.
- R10: Each cycle with `cmd_valid` high is followed one cycle later by exactly one pulse, on either `cmd_accept` or `cmd_reject`. Neither output is ever high at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above write threshold, synchronous |
| cmd_valid | input | 1 | Decoded instruction strobe, one cycle per instruction |
| cmd_code | input | 8 | Decoded opcode |
| op_done | input | 1 | Program/erase/status-write completion pulse |
| cmd_accept | output | 1 | Instruction admitted (one cycle after strobe) |
| cmd_reject | output | 1 | Instruction refused (one cycle after strobe) |
| wel | output | 1 | Write-enable latch value |
| inhibit | output | 1 | Supply low or power-up window still open |

## Verification
The properties assume three things about the inputs. `supply_ok` is already synchronous to `clk`. `op_done` is a single-cycle pulse. `cmd_code` is meaningful only while `cmd_valid` is high. The stimulus changes inputs a fixed delay after each rising edge, pulses `op_done` for one cycle only, and places back-to-back strobes, window-edge instructions and a supply drop in the middle of a sequence. The responses are then compared against a behavioural model of the gate on every cycle.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;

  typedef enum logic [2:0] {
    CLS_READ,
    CLS_WREN,
    CLS_WRDI,
    CLS_MODIFY,
    CLS_PDOWN,
    CLS_RELPD
  } cmd_class_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_PDOWN = 8'hB9;
  localparam logic [7:0] OP_RELPD = 8'hAB;

  localparam int NUM_MOD = 7;
  localparam logic [7:0] MOD_OPS [NUM_MOD] =
    '{8'h02, 8'h20, 8'h52, 8'hD8, 8'hC7, 8'h60, 8'h01};

  function automatic logic is_modify_op(input logic [7:0] c);
    logic m;
    m = 1'b0;
    for (int i = 0; i < NUM_MOD; i++)
      if (c == MOD_OPS[i]) m = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/fg_cmd_decode.sv
module fg_cmd_decode
  import flash_gate_pkg::*;
(
  input  logic [7:0]  code,
  output cmd_class_e  cls
);
  logic [NUM_MOD-1:0] hit;

  for (genvar g = 0; g < NUM_MOD; g++) begin : g_mod
    assign hit[g] = (code == MOD_OPS[g]);
  end

  always_comb begin
    if (|hit) cls = CLS_MODIFY;
    else begin
      case (code)
        OP_WREN:  cls = CLS_WREN;
        OP_WRDI:  cls = CLS_WRDI;
        OP_PDOWN: cls = CLS_PDOWN;
        OP_RELPD: cls = CLS_RELPD;
        default:  cls = CLS_READ;
      endcase
    end
  end
endmodule

// File: rtl/fg_pwrup_timer.sv
module fg_pwrup_timer #(
  parameter int PUW_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic inhibit
);
  localparam int CW = (PUW_CYCLES < 1) ? 1 : $clog2(PUW_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PUW_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!supply_ok)     cnt <= '0;
    else if (cnt != LIMIT)   cnt <= cnt + 1'b1;
  end

  assign inhibit = !supply_ok || (cnt != LIMIT);
endmodule

// File: rtl/fg_gate_core.sv
module fg_gate_core
  import flash_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       cmd_valid,
  input  cmd_class_e cls,
  input  logic       inhibit,
  input  logic       op_done,
  output logic       accept,
  output logic       reject,
  output logic       wel
);
  logic pd, take, wel_n, pd_n;

  always_comb begin
    take  = 1'b1;
    wel_n = wel;
    pd_n  = pd;
    if (op_done) wel_n = 1'b0;
    if (cmd_valid) begin
      if (pd) begin
        take = (cls == CLS_RELPD);
        if (take) pd_n = 1'b0;
      end else begin
        case (cls)
          CLS_WREN: begin
            take = !inhibit;
            if (take) wel_n = 1'b1;
          end
          CLS_WRDI:   wel_n = 1'b0;
          CLS_MODIFY: take  = !inhibit && wel;
          CLS_PDOWN:  pd_n  = 1'b1;
          default:    take  = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel    <= 1'b0;
      pd     <= 1'b0;
      accept <= 1'b0;
      reject <= 1'b0;
    end else if (!supply_ok) begin
      wel    <= 1'b0;
      pd     <= 1'b0;
      accept <= 1'b0;
      reject <= cmd_valid;
    end else begin
      wel    <= wel_n;
      pd     <= pd_n;
      accept <= cmd_valid && take;
      reject <= cmd_valid && !take;
    end
  end
endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate
  import flash_gate_pkg::*;
#(
  parameter int PUW_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       op_done,
  output logic       cmd_accept,
  output logic       cmd_reject,
  output logic       wel,
  output logic       inhibit
);
  cmd_class_e cls;

  fg_cmd_decode u_dec (
    .code (cmd_code),
    .cls  (cls)
  );

  fg_pwrup_timer #(.PUW_CYCLES(PUW_CYCLES)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .inhibit   (inhibit)
  );

  fg_gate_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .cmd_valid (cmd_valid),
    .cls       (cls),
    .inhibit   (inhibit),
    .op_done   (op_done),
    .accept    (cmd_accept),
    .reject    (cmd_reject),
    .wel       (wel)
  );
endmodule

// File: rtl/flash_cmd_gate_chk.sv
module flash_cmd_gate_chk
  import flash_gate_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       cmd_valid,
  input logic [7:0] cmd_code,
  input logic       op_done,
  input logic       cmd_accept,
  input logic       cmd_reject,
  input logic       wel,
  input logic       inhibit
);
  assert_single_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_accept, cmd_reject}));

  assert_verdict_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept || cmd_reject) |-> $past(cmd_valid));

  assert_low_supply_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!wel && !cmd_accept));

  assert_low_supply_inhibits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> inhibit);

  assert_wren_blocked_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == OP_WREN && inhibit) |=> cmd_reject);

  assert_modify_needs_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_modify_op(cmd_code) && !wel) |=> (cmd_reject && !wel));

  assert_done_clears_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !cmd_valid) |=> !wel);

  assert_wrdi_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == OP_WRDI) |=> (!wel || cmd_reject));
endmodule

bind flash_cmd_gate flash_cmd_gate_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .supply_ok  (supply_ok),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .op_done    (op_done),
  .cmd_accept (cmd_accept),
  .cmd_reject (cmd_reject),
  .wel        (wel),
  .inhibit    (inhibit)
);

// File: tb/tb_flash_cmd_gate.sv
module tb_flash_cmd_gate;
  localparam int PUW = 16;

  logic clk = 1'b0, rst_n = 1'b0, supply_ok = 1'b0;
  logic cmd_valid = 1'b0, op_done = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic cmd_accept, cmd_reject, wel, inhibit;

  int vectors = 0, miscompares = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_gate #(.PUW_CYCLES(PUW)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .op_done(op_done), .cmd_accept(cmd_accept),
    .cmd_reject(cmd_reject), .wel(wel), .inhibit(inhibit)
  );

  // behavioural reference model
  byte unsigned mod_q[$] = '{8'h02, 8'h20, 8'h52, 8'hD8, 8'hC7, 8'h60, 8'h01};
  int m_cnt = 0;
  bit m_wel = 0, m_pd = 0, m_acc = 0, m_rej = 0;

  function automatic bit in_mod(byte unsigned c);
    foreach (mod_q[i]) if (mod_q[i] == c) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    bit ok, nw, np, inh;
    if (!rst_n) begin
      m_cnt = 0; m_wel = 0; m_pd = 0; m_acc = 0; m_rej = 0;
    end else if (!supply_ok) begin
      m_cnt = 0; m_wel = 0; m_pd = 0; m_acc = 0; m_rej = cmd_valid;
    end else begin
      inh = (m_cnt != PUW);
      ok = 1; nw = m_wel; np = m_pd;
      if (op_done) nw = 0;
      if (cmd_valid) begin
        if (m_pd) begin
          ok = (cmd_code == 8'hAB);
          if (ok) np = 0;
        end else if (cmd_code == 8'h06) begin
          ok = !inh;
          if (ok) nw = 1;
        end else if (cmd_code == 8'h04) nw = 0;
        else if (in_mod(cmd_code)) ok = !inh && m_wel;
        else if (cmd_code == 8'hB9) np = 1;
      end
      m_acc = cmd_valid && ok;
      m_rej = cmd_valid && !ok;
      m_wel = nw; m_pd = np;
      if (m_cnt < PUW) m_cnt++;
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "cmd_accept", cmd_accept, m_acc);
      check(cur_req, "cmd_reject", cmd_reject, m_rej);
      check("R3", "wel", wel, m_wel);
      check("R2", "inhibit", inhibit, (!supply_ok || m_cnt != PUW));
    end
  end

  task automatic send(byte unsigned c, string req);
    @(posedge clk); #5;
    cur_req = req; cmd_valid = 1'b1; cmd_code = c;
    @(posedge clk); #5;
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_done(string req);
    @(posedge clk); #5;
    cur_req = req; op_done = 1'b1;
    @(posedge clk); #5;
    op_done = 1'b0;
  endtask

  task automatic raise_supply_and_time();
    int n = 0;
    @(posedge clk); #5;
    supply_ok = 1'b1; cur_req = "R2";
    for (int k = 0; k < 4 * PUW; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!inhibit) break;
    end
    vectors++;
    if (n != PUW) begin
      miscompares++;
      $display("FAIL R2 window length actual=%0d expected=%0d", n, PUW);
    end
  endtask

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    // R1 / R3: supply low, everything refused
    send(8'h06, "R1"); send(8'h02, "R1"); send(8'h03, "R1");
    // R2 window: modifying blocked, others pass
    @(posedge clk); #5 supply_ok = 1'b1;
    send(8'h06, "R2"); send(8'h02, "R2");
    send(8'h03, "R9"); send(8'h04, "R7");
    repeat (PUW) @(posedge clk);
    // R5 without latch
    send(8'h02, "R5");
    send(8'h06, "R4"); send(8'h0B, "R9");
    foreach (mod_q[i]) begin
      send(mod_q[i], "R5");
      pulse_done("R6");
      send(mod_q[i], "R5");
      send(8'h06, "R4");
    end
    // op_done with concurrent write enable
    @(posedge clk); #5;
    cur_req = "R6"; op_done = 1'b1; cmd_valid = 1'b1; cmd_code = 8'h06;
    @(posedge clk); #5; op_done = 1'b0; cmd_valid = 1'b0;
    send(8'h04, "R7"); send(8'h20, "R5");
    // R8 power-down
    send(8'h06, "R4"); send(8'hB9, "R8");
    send(8'h04, "R8"); send(8'h06, "R8"); send(8'h02, "R8"); send(8'h03, "R8");
    pulse_done("R8");
    send(8'h06, "R8"); send(8'hAB, "R8");
    send(8'h06, "R4"); send(8'hAB, "R9"); send(8'hD8, "R5");
    // back-to-back strobes
    @(posedge clk); #5; cur_req = "R10"; cmd_valid = 1'b1; cmd_code = 8'h06;
    @(posedge clk); #5; cmd_code = 8'hC7;
    @(posedge clk); #5; cmd_code = 8'h05;
    @(posedge clk); #5; cmd_valid = 1'b0;
    // R1 supply drop mid-sequence, then timed window
    send(8'h06, "R4"); send(8'hB9, "R8");
    @(posedge clk); #5 supply_ok = 1'b0;
    send(8'hAB, "R1"); send(8'h06, "R1");
    raise_supply_and_time();
    send(8'h06, "R4"); send(8'h01, "R5");
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule